// File: doc/BRIEF.md
# Sleep Mode and Wakeup Controller

This block sits beside a small 8-bit processor core and decides when the core sleeps and when it wakes. Software writes one 8-bit control register. Setting its low bit puts the core into a light sleep: the CPU clock is gated and everything else keeps running. Setting the next bit puts the core into deep sleep: the oscillator enable is dropped as well. Six upper bits are plain storage that software may read and write. They have no effect on operation.

Interrupt requests wake the core. Each request has an enable and a priority. A light sleep ends on any enabled request. A deep sleep ends only on an enabled request that outranks whatever interrupt is already in service. After a deep-sleep wakeup the oscillator enable returns at once. The CPU clock stays off until a stabilization count has run out. That count is longer for a crystal than for an RC or external clock. When it runs out, a one-cycle strobe marks the end of the wakeup. One request line can be marked as the brownout source. It takes part in wakeup only when brownout detection is switched on and brownout is set to act as an interrupt.

Top module: `pmu_sleep_ctrl`

## Requirements
- R1: After reset the control register reads 00h. A write made while running stores bits 7..2, and those bits read back unchanged. The register reads bit 1 as 1 exactly while in deep sleep and bit 0 as 1 exactly while in light sleep.
- R2: A write made while running with bit 0 = 1 and bit 1 = 0 enters light sleep on the next cycle. In light sleep, cpu_clk_en_o is 0, osc_en_o stays 1 and register bit 0 reads 1.
- R3: A write made while running with bit 1 = 1 enters deep sleep on the next cycle. In deep sleep, osc_en_o and cpu_clk_en_o are both 0 and register bit 1 reads 1.
- R4: Light sleep ends one cycle after any request whose request and enable bits are both 1, whatever its priority. The core then runs again and bit 0 reads 0. A request whose enable is 0 leaves the core in light sleep.
- R5: Deep sleep ends only on an enabled request whose priority is strictly greater than svc_prio_i while svc_active_i = 1, or on any enabled request while svc_active_i = 0. An enabled request whose priority is lower than or equal to the in-service priority leaves the core in deep sleep, and so does a disabled request.
- R6: On a deep-sleep wakeup, osc_en_o returns to 1 on the next cycle and bit 1 reads 0. cpu_clk_en_o stays 0 for exactly 1024 cycles when clk_src_xtal_i = 1, or 256 cycles when it is 0. wake_done_o is 1 only in the last of those cycles, and cpu_clk_en_o returns to 1 on the cycle after.
- R7: The request at index BOD_IDX (default 0) counts for wakeup only when bod_off_i = 0 and bod_as_irq_i = 1.
- R8: A single write with both bit 1 and bit 0 set enters deep sleep, not light sleep. Afterwards the register reads bit 1 = 1 and bit 0 = 0.
- R9: Reset in any mode returns the block to running, with cpu_clk_en_o = 1, osc_en_o = 1, wake_done_o = 0 and the register at 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (the restarted oscillator clock) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| irq_req_i | input | N_SRC | Interrupt request per source |
| irq_en_i | input | N_SRC | Interrupt enable per source |
| irq_prio_i | input | N_SRC*PRIO_W | Priority per source, source i in bits [i*PRIO_W +: PRIO_W] |
| svc_active_i | input | 1 | An interrupt is currently in service |
| svc_prio_i | input | PRIO_W | Priority of the interrupt in service |
| bod_off_i | input | 1 | Brownout detection switched off |
| bod_as_irq_i | input | 1 | Brownout configured as an interrupt |
| clk_src_xtal_i | input | 1 | 1 = crystal clock source, 0 = RC or external clock |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| wake_done_o | output | 1 | One-cycle strobe at the end of stabilization |

## Verification
The assertions take it for granted that register writes arrive only while the CPU clock is enabled, since a gated core cannot issue them. They also assume that clk_src_xtal_i holds steady through each stabilization window, because the window check measures against the value seen at its end. The stimulus writes only while cpu_clk_en_o is 1. It changes the clock-source select only while the core is running. It raises and drops requests only on the falling edge, so the wake decision always sees settled values.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2,
      PM_STAB = 2'd3
   } pm_mode_e;

   localparam int unsigned REG_W   = 8;
   localparam int unsigned BIT_IDL = 0;
   localparam int unsigned BIT_PD  = 1;
   localparam int unsigned FLAG_LO = 2;

endpackage

// File: rtl/pmu_wake_eval.sv
module pmu_wake_eval #(
   parameter int unsigned N_SRC   = 4,
   parameter int unsigned PRIO_W  = 2,
   parameter int unsigned BOD_IDX = 0
) (
   input  logic [N_SRC-1:0]        irq_req_i,
   input  logic [N_SRC-1:0]        irq_en_i,
   input  logic [N_SRC*PRIO_W-1:0] irq_prio_i,
   input  logic                    svc_active_i,
   input  logic [PRIO_W-1:0]       svc_prio_i,
   input  logic                    bod_off_i,
   input  logic                    bod_as_irq_i,
   output logic                    any_req_o,
   output logic                    any_beat_o
);

   logic [N_SRC-1:0] qual;
   logic [N_SRC-1:0] beat;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic gate;
      logic [PRIO_W-1:0] prio;
      if (i == BOD_IDX) begin : g_bod
         assign gate = !bod_off_i && bod_as_irq_i;
      end else begin : g_plain
         assign gate = 1'b1;
      end
      assign prio    = irq_prio_i[i*PRIO_W +: PRIO_W];
      assign qual[i] = irq_req_i[i] && irq_en_i[i] && gate;
      assign beat[i] = qual[i] && (!svc_active_i || (prio > svc_prio_i));
   end

   assign any_req_o  = |qual;
   assign any_beat_o = |beat;

endmodule

// File: rtl/pmu_stab_timer.sv
module pmu_stab_timer #(
   parameter int unsigned XTAL_CYC = 1024,
   parameter int unsigned RC_CYC   = 256
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic run_i,
   input  logic xtal_i,
   output logic done_o
);

   localparam int unsigned MAX_CYC = (XTAL_CYC > RC_CYC) ? XTAL_CYC : RC_CYC;
   localparam int unsigned CW      = $clog2(MAX_CYC);
   localparam logic [CW-1:0] XT_LAST = CW'(XTAL_CYC - 1);
   localparam logic [CW-1:0] RC_LAST = CW'(RC_CYC - 1);

   logic [CW-1:0] cnt_q;
   logic          xtal_q;
   logic [CW-1:0] last;

   assign last   = xtal_q ? XT_LAST : RC_LAST;
   assign done_o = run_i && (cnt_q == last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         xtal_q <= 1'b1;
      end else if (start_i) begin
         cnt_q  <= '0;
         xtal_q <= xtal_i;
      end else if (run_i) begin
         cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
   import pmu_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             idle_wake_i,
   input  logic             pd_wake_i,
   input  logic             stab_done_i,
   output pm_mode_e         mode_o,
   output logic [REG_W-1:0] rd_data_o
);

   localparam int unsigned FW = REG_W - FLAG_LO;

   pm_mode_e      mode_q;
   logic [FW-1:0] flags_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q  <= PM_RUN;
         flags_q <= '0;
      end else begin
         unique case (mode_q)
            PM_RUN: if (wr_en_i) begin
               flags_q <= wr_data_i[REG_W-1:FLAG_LO];
               if (wr_data_i[BIT_PD])       mode_q <= PM_DOWN;
               else if (wr_data_i[BIT_IDL]) mode_q <= PM_IDLE;
            end
            PM_IDLE: if (idle_wake_i) mode_q <= PM_RUN;
            PM_DOWN: if (pd_wake_i)   mode_q <= PM_STAB;
            PM_STAB: if (stab_done_i) mode_q <= PM_RUN;
            default: mode_q <= PM_RUN;
         endcase
      end
   end

   assign mode_o    = mode_q;
   assign rd_data_o = {flags_q, (mode_q == PM_DOWN), (mode_q == PM_IDLE)};

endmodule

// File: rtl/pmu_sleep_ctrl.sv
module pmu_sleep_ctrl
   import pmu_pkg::*;
#(
   parameter int unsigned N_SRC    = 4,
   parameter int unsigned PRIO_W   = 2,
   parameter int unsigned BOD_IDX  = 0,
   parameter int unsigned XTAL_CYC = 1024,
   parameter int unsigned RC_CYC   = 256
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_en_i,
   input  logic [7:0]              wr_data_i,
   output logic [7:0]              rd_data_o,
   input  logic [N_SRC-1:0]        irq_req_i,
   input  logic [N_SRC-1:0]        irq_en_i,
   input  logic [N_SRC*PRIO_W-1:0] irq_prio_i,
   input  logic                    svc_active_i,
   input  logic [PRIO_W-1:0]       svc_prio_i,
   input  logic                    bod_off_i,
   input  logic                    bod_as_irq_i,
   input  logic                    clk_src_xtal_i,
   output logic                    cpu_clk_en_o,
   output logic                    osc_en_o,
   output logic                    wake_done_o
);

   if (N_SRC < 1 || PRIO_W < 1) begin : g_bad_src
      $error("pmu_sleep_ctrl: N_SRC and PRIO_W must be at least 1");
   end
   if (BOD_IDX >= N_SRC) begin : g_bad_bod
      $error("pmu_sleep_ctrl: BOD_IDX must index an existing source");
   end
   if (XTAL_CYC < 2 || RC_CYC < 2) begin : g_bad_cyc
      $error("pmu_sleep_ctrl: stabilization counts must be at least 2");
   end

   logic     any_req, any_beat, stab_done;
   pm_mode_e mode;

   pmu_wake_eval #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .BOD_IDX(BOD_IDX)) u_wake (
      .irq_req_i    (irq_req_i),
      .irq_en_i     (irq_en_i),
      .irq_prio_i   (irq_prio_i),
      .svc_active_i (svc_active_i),
      .svc_prio_i   (svc_prio_i),
      .bod_off_i    (bod_off_i),
      .bod_as_irq_i (bod_as_irq_i),
      .any_req_o    (any_req),
      .any_beat_o   (any_beat)
   );

   pmu_mode_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .wr_data_i   (wr_data_i),
      .idle_wake_i (any_req),
      .pd_wake_i   (any_beat),
      .stab_done_i (stab_done),
      .mode_o      (mode),
      .rd_data_o   (rd_data_o)
   );

   pmu_stab_timer #(.XTAL_CYC(XTAL_CYC), .RC_CYC(RC_CYC)) u_stab (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i ((mode == PM_DOWN) && any_beat),
      .run_i   (mode == PM_STAB),
      .xtal_i  (clk_src_xtal_i),
      .done_o  (stab_done)
   );

   assign cpu_clk_en_o = (mode == PM_RUN);
   assign osc_en_o     = (mode != PM_DOWN);
   assign wake_done_o  = stab_done;

endmodule

// File: rtl/pmu_sleep_chk.sv
module pmu_sleep_chk #(
   parameter int unsigned XTAL_CYC = 1024,
   parameter int unsigned RC_CYC   = 256
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       wr_en_i,
   input logic [7:0] wr_data_i,
   input logic [7:0] rd_data_o,
   input logic       clk_src_xtal_i,
   input logic       cpu_clk_en_o,
   input logic       osc_en_o,
   input logic       wake_done_o
);

   logic [15:0] win_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           win_q <= '0;
      else if (!osc_en_o || cpu_clk_en_o)    win_q <= '0;
      else if (!rd_data_o[0])                win_q <= win_q + 16'd1;
   end

   a_r2_idle_keeps_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[0] |-> (!cpu_clk_en_o && osc_en_o));

   a_r3_down_stops_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[1] |-> (!cpu_clk_en_o && !osc_en_o));

   a_r8_down_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_clk_en_o && wr_en_i && wr_data_i[1]) |=> (rd_data_o[1] && !rd_data_o[0]));

   a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_done_o |=> !wake_done_o);

   a_r6_done_then_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_done_o |=> cpu_clk_en_o);

   a_r6_done_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_done_o |-> (32'(win_q) == (clk_src_xtal_i ? XTAL_CYC - 1 : RC_CYC - 1)));

   a_r6_no_done_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_clk_en_o |-> !wake_done_o);

endmodule

bind pmu_sleep_ctrl pmu_sleep_chk #(.XTAL_CYC(XTAL_CYC), .RC_CYC(RC_CYC)) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .wr_en_i        (wr_en_i),
   .wr_data_i      (wr_data_i),
   .rd_data_o      (rd_data_o),
   .clk_src_xtal_i (clk_src_xtal_i),
   .cpu_clk_en_o   (cpu_clk_en_o),
   .osc_en_o       (osc_en_o),
   .wake_done_o    (wake_done_o)
);

// File: tb/pmu_sleep_ctrl_tb.sv
module pmu_sleep_ctrl_tb_top;

   localparam int N  = 4;
   localparam int PW = 2;
   localparam int XT = 1024;
   localparam int RC = 256;
   localparam int BOD = 0;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic [N-1:0]  req = '0, en = '0;
   logic [N*PW-1:0] prio = '0;
   logic          svc_act = 1'b0;
   logic [PW-1:0] svc_prio = '0;
   logic          bod_off = 1'b0, bod_irq = 1'b1, xtal = 1'b1;
   logic          clk_en, osc_en, done;

   pmu_sleep_ctrl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .irq_req_i(req), .irq_en_i(en), .irq_prio_i(prio),
      .svc_active_i(svc_act), .svc_prio_i(svc_prio), .bod_off_i(bod_off),
      .bod_as_irq_i(bod_irq), .clk_src_xtal_i(xtal), .cpu_clk_en_o(clk_en),
      .osc_en_o(osc_en), .wake_done_o(done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Behavioural reference: 0 run, 1 light sleep, 2 deep sleep, 3 settling
   int         m_mode = 0;
   int         m_cnt  = 0;
   int         m_len  = XT;
   logic [5:0] m_flags = '0;

   function automatic bit m_wake(input bit need_rank);
      bit hit = 0;
      for (int i = 0; i < N; i++) begin
         bit ok = req[i] && en[i];
         if (i == BOD && (bod_off || !bod_irq)) ok = 0;
         if (need_rank && svc_act && !(int'(prio[i*PW +: PW]) > int'(svc_prio))) ok = 0;
         if (ok) hit = 1;
      end
      return hit;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_flags = '0; m_cnt = 0;
      end else begin
         case (m_mode)
            0: if (wr_en) begin
                  m_flags = wr_data[7:2];
                  if (wr_data[1]) m_mode = 2;
                  else if (wr_data[0]) m_mode = 1;
               end
            1: if (m_wake(0)) m_mode = 0;
            2: if (m_wake(1)) begin m_mode = 3; m_cnt = 0; m_len = xtal ? XT : RC; end
            default: if (m_cnt == m_len - 1) m_mode = 0; else m_cnt++;
         endcase
      end
   end

   always @(negedge clk) begin
      chk("R1 register read", int'(rd_data), int'({m_flags, m_mode == 2, m_mode == 1}));
      chk("R2 cpu clock enable", int'(clk_en), int'(m_mode == 0));
      chk("R3 oscillator enable", int'(osc_en), int'(m_mode != 2));
      chk("R6 wake done", int'(done), int'(m_mode == 3 && m_cnt == m_len - 1));
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic measure(input string tag, input int expv);
      int n = 0;
      int at = -1;
      while (osc_en === 1'b1 && clk_en === 1'b0 && n < 5000) begin
         n++;
         if (done === 1'b1) at = n;
         @(negedge clk);
      end
      chk({tag, " settle length"}, n, expv);
      chk({tag, " strobe position"}, at, expv);
      chk({tag, " clock back"}, int'(clk_en), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      cyc(3);
      chk("R9 reset register", int'(rd_data), 0);
      chk("R9 reset clocks", int'({clk_en, osc_en, done}), 3'b110);
      rst_n = 1'b1;
      cyc(1);

      // R1 flag storage
      wr(8'hFC);
      chk("R1 flags FC", int'(rd_data), 8'hFC);
      wr(8'h54);
      chk("R1 flags 54", int'(rd_data), 8'h54);

      // R2 light sleep, R4 wake
      wr(8'h55);
      chk("R2 idle read", int'(rd_data), 8'h55);
      chk("R2 idle clocks", int'({clk_en, osc_en}), 2'b01);
      req[2] = 1'b1; en[2] = 1'b0;
      cyc(3);
      chk("R4 disabled req holds idle", int'(clk_en), 0);
      svc_act = 1'b1; svc_prio = 2'd3; prio[4 +: 2] = 2'd0; en[2] = 1'b1;
      cyc(1);
      chk("R4 idle wake any priority", int'(clk_en), 1);
      chk("R4 idle bit cleared", int'(rd_data), 8'h54);
      req = '0; en = '0;

      // R3 deep sleep, R5 ranking, R6 crystal settle
      wr(8'h02);
      chk("R3 down read", int'(rd_data), 8'h02);
      chk("R3 down clocks", int'({clk_en, osc_en}), 0);
      svc_prio = 2'd2; req[2] = 1'b1; en[2] = 1'b1; prio[4 +: 2] = 2'd1;
      cyc(3);
      chk("R5 lower priority holds", int'(osc_en), 0);
      prio[4 +: 2] = 2'd2;
      cyc(3);
      chk("R5 equal priority holds", int'(osc_en), 0);
      en[2] = 1'b0; prio[4 +: 2] = 2'd3;
      cyc(3);
      chk("R5 disabled holds", int'(osc_en), 0);
      en[2] = 1'b1;
      cyc(1);
      req = '0; en = '0;
      chk("R6 osc restarts", int'({osc_en, clk_en}), 2'b10);
      chk("R6 down bit cleared", int'(rd_data), 0);
      measure("R6 crystal", XT);

      // R6 RC settle, R5 nothing in service
      xtal = 1'b0; svc_act = 1'b0; prio = '0;
      wr(8'h02);
      req[3] = 1'b1; en[3] = 1'b1;
      cyc(1);
      req = '0; en = '0;
      measure("R6 rc", RC);

      // R7 brownout qualification
      wr(8'h01);
      req[BOD] = 1'b1; en[BOD] = 1'b1; bod_off = 1'b1; bod_irq = 1'b1;
      cyc(3);
      chk("R7 detector off holds", int'(clk_en), 0);
      bod_off = 1'b0; bod_irq = 1'b0;
      cyc(3);
      chk("R7 not interrupt holds", int'(clk_en), 0);
      bod_irq = 1'b1;
      cyc(1);
      chk("R7 brownout wakes", int'(clk_en), 1);
      req = '0; en = '0;

      // R8 both bits
      wr(8'h03);
      chk("R8 down wins read", int'(rd_data), 8'h02);
      chk("R8 down wins osc", int'(osc_en), 0);

      // R9 reset from deep sleep
      cyc(2);
      rst_n = 1'b0;
      cyc(2);
      chk("R9 reset from down", int'({rd_data, clk_en, osc_en, done}), {8'h00, 3'b110});
      rst_n = 1'b1;
      cyc(2);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule